// File: doc/BRIEF.md
# Posted-Store Buffer with Read-Miss Forwarding

This block sits between a write-through cache and a slower memory port. When the processor stores, the store goes into the cache and into this buffer in the same cycle. The processor sees the store as complete as soon as the buffer takes it, and it never waits for memory. A drain port then hands the buffered stores to memory one at a time, oldest first. The drain runs in the background and does not depend on what the processor does. If stores arrive faster than memory takes them, the buffer fills and further stores stall.

A read miss that is about to fill a line can read stale memory while newer stores are still queued. The block closes this gap in one of two ways, chosen by a parameter. In forward mode, the lookup address is compared with every pending entry at once. Each byte is returned from the youngest pending store that wrote it, and from memory otherwise. In flush-first mode, the read miss is held back until the buffer has drained completely. Addresses are word addresses. Each entry holds an address, a data word and one strobe bit per byte (bit n covers data bits 8n+7..8n).

Both streams use valid/ready handshakes:
- A transfer happens in a cycle where valid and ready are both high.
- The store side lowers `st_ready` when the buffer is full, even if an entry leaves in that same cycle.
- The drain side keeps `mem_valid` and its payload unchanged until `mem_ready` accepts it.

Top module: `wbuf_fwd`

## Requirements
- R1: `st_ready` is high whenever fewer than DEPTH entries are held. A store is accepted in any cycle where `st_valid` and `st_ready` are both high.
- R2: `st_ready` is low while DEPTH entries are held. A store offered then is not taken, and it is taken once space frees.
- R3: `mem_valid` is high exactly when at least one entry is held. `mem_addr`, `mem_data` and `mem_strb` show the oldest held entry. Entries reach memory in the order they were accepted.
- R4: While `mem_valid` is high and `mem_ready` is low, the drain payload stays unchanged in the next cycle.
- R5: After reset, the buffer is empty: `st_ready` is high and `mem_valid` is low.
- R6: In forward mode, each byte of `rd_data` comes from the youngest held entry at `rd_addr` whose strobe for that byte is set. Bytes with no such entry come from `rd_mem_data`. `rd_hit` is high when any held entry has address `rd_addr`.
- R7: In forward mode, a store accepted in the same cycle as a lookup counts as the youngest entry for that lookup.
- R8: In forward mode, an entry that drains in the same cycle as a lookup is still searched by that lookup.
- R9: In flush-first mode:
  - `rd_go` is high only when no entry is held and no store is offered.
  - `rd_data` equals `rd_mem_data`.
  - `rd_hit` stays low.
- R10: In forward mode, `rd_go` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Buffer can accept a store |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_strb | input | DW/8 | Store byte strobes |
| mem_valid | output | 1 | Drain entry available |
| mem_ready | input | 1 | Memory accepts the drain entry |
| mem_addr | output | AW | Address of the oldest entry |
| mem_data | output | DW | Data of the oldest entry |
| mem_strb | output | DW/8 | Strobes of the oldest entry |
| rd_addr | input | AW | Read-miss lookup address |
| rd_mem_data | input | DW | Word read from memory for the lookup |
| rd_data | output | DW | Word after merging pending stores |
| rd_hit | output | 1 | A pending store matches the lookup |
| rd_go | output | 1 | The read miss may go to memory |

## Verification
- **Occupancy faults.** A wrong occupancy count shows at once in `st_ready` or `mem_valid`, in the same cycle as the state goes wrong.
- **Pointer faults.** A wrong read or write pointer shows one cycle later. Either `mem_addr` shows an entry out of order, or the forwarded word differs from a shadow memory that applies every accepted store in program order.
- **Search faults.** A wrong age order in the lookup shows only when two pending stores hit the same address and strobe overlapping bytes. The stimulus therefore uses a handful of addresses so that such collisions are common.
- **Flush-first faults.** A flush-first design that releases a read miss too early is caught on that cycle. The bench compares the memory model against the shadow memory whenever `rd_go` is high.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
package wbuf_pkg;
  typedef enum logic {
    WB_FORWARD     = 1'b0,
    WB_FLUSH_FIRST = 1'b1
  } wb_mode_e;
endpackage

// File: rtl/wbuf_store.sv
`timescale 1ns/1ps
// Circular entry store with head/tail pointers and an occupancy count.
module wbuf_store #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int SW   = DW / 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [AW-1:0]                 push_addr,
  input  logic [DW-1:0]                 push_data,
  input  logic [SW-1:0]                 push_strb,
  input  logic                          pop,
  output logic [DEPTH-1:0][AW-1:0]      ent_addr,
  output logic [DEPTH-1:0][DW-1:0]      ent_data,
  output logic [DEPTH-1:0][SW-1:0]      ent_strb,
  output logic [PW-1:0]                 head_ptr,
  output logic [CW-1:0]                 count
);

  logic [PW-1:0] tail_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Payload storage needs no reset: occupancy qualifies every read.
  always_ff @(posedge clk) begin
    if (push) begin
      ent_addr[tail_ptr] <= push_addr;
      ent_data[tail_ptr] <= push_data;
      ent_strb[tail_ptr] <= push_strb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_ptr <= '0;
      head_ptr <= '0;
      count    <= '0;
    end else begin
      if (push) tail_ptr <= bump(tail_ptr);
      if (pop)  head_ptr <= bump(head_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/wbuf_search.sv
`timescale 1ns/1ps
// Associative lookup over all live entries plus the incoming store,
// resolved per byte with the youngest writer winning.
module wbuf_search #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int SW   = DW / 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][AW-1:0] ent_addr,
  input  logic [DEPTH-1:0][DW-1:0] ent_data,
  input  logic [DEPTH-1:0][SW-1:0] ent_strb,
  input  logic [PW-1:0]            head_ptr,
  input  logic [CW-1:0]            count,
  input  logic                     new_vld,
  input  logic [AW-1:0]            new_addr,
  input  logic [DW-1:0]            new_data,
  input  logic [SW-1:0]            new_strb,
  input  logic [AW-1:0]            look_addr,
  input  logic [DW-1:0]            base_data,
  output logic [DW-1:0]            merged,
  output logic                     hit
);

  // Entries rearranged by age: index 0 is the oldest.
  logic [DEPTH-1:0]          match_age;
  logic [DEPTH-1:0][DW-1:0]  data_age;
  logic [DEPTH-1:0][SW-1:0]  strb_age;
  logic                      new_match;

  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    logic [PW:0]   raw;
    logic [PW-1:0] idx;
    logic          live;
    assign raw  = {1'b0, head_ptr} + (PW+1)'(k);
    assign idx  = (raw >= (PW+1)'(DEPTH)) ? PW'(raw - (PW+1)'(DEPTH)) : PW'(raw);
    assign live = CW'(k) < count;
    assign match_age[k] = live && (ent_addr[idx] == look_addr);
    assign data_age[k]  = ent_data[idx];
    assign strb_age[k]  = ent_strb[idx];
  end

  assign new_match = new_vld && (new_addr == look_addr);

  for (genvar b = 0; b < SW; b++) begin : g_byte
    logic [7:0] byte_v;
    always_comb begin
      byte_v = base_data[b*8 +: 8];
      for (int k = 0; k < DEPTH; k++) begin
        if (match_age[k] && strb_age[k][b]) byte_v = data_age[k][b*8 +: 8];
      end
      if (new_match && new_strb[b]) byte_v = new_data[b*8 +: 8];
    end
    assign merged[b*8 +: 8] = byte_v;
  end

  assign hit = (|match_age) || new_match;

endmodule

// File: rtl/wbuf_fwd.sv
`timescale 1ns/1ps
// Posted-store buffer: FIFO drain to memory, read-miss forwarding or flush-first.
module wbuf_fwd
  import wbuf_pkg::*;
#(
  parameter int       DEPTH = 4,
  parameter int       AW    = 16,
  parameter int       DW    = 32,
  parameter wb_mode_e MODE  = WB_FORWARD,
  localparam int      SW    = DW / 8,
  localparam int      PW    = $clog2(DEPTH),
  localparam int      CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [SW-1:0] st_strb,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic [SW-1:0] mem_strb,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_mem_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_hit,
  output logic          rd_go
);

  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0][DW-1:0] ent_data;
  logic [DEPTH-1:0][SW-1:0] ent_strb;
  logic [PW-1:0]            head_ptr;
  logic [CW-1:0]            count;
  logic                     st_fire;
  logic                     mem_fire;

  assign st_ready  = (count != CW'(DEPTH));
  assign mem_valid = (count != '0);
  assign st_fire   = st_valid && st_ready;
  assign mem_fire  = mem_valid && mem_ready;

  wbuf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (st_fire),
    .push_addr (st_addr),
    .push_data (st_data),
    .push_strb (st_strb),
    .pop       (mem_fire),
    .ent_addr  (ent_addr),
    .ent_data  (ent_data),
    .ent_strb  (ent_strb),
    .head_ptr  (head_ptr),
    .count     (count)
  );

  assign mem_addr = ent_addr[head_ptr];
  assign mem_data = ent_data[head_ptr];
  assign mem_strb = ent_strb[head_ptr];

  if (MODE == WB_FORWARD) begin : g_forward
    wbuf_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_search (
      .ent_addr  (ent_addr),
      .ent_data  (ent_data),
      .ent_strb  (ent_strb),
      .head_ptr  (head_ptr),
      .count     (count),
      .new_vld   (st_fire),
      .new_addr  (st_addr),
      .new_data  (st_data),
      .new_strb  (st_strb),
      .look_addr (rd_addr),
      .base_data (rd_mem_data),
      .merged    (rd_data),
      .hit       (rd_hit)
    );
    assign rd_go = 1'b1;
  end else begin : g_flush
    // Memory is only trusted once nothing is pending or arriving.
    assign rd_data = rd_mem_data;
    assign rd_hit  = 1'b0;
    assign rd_go   = (count == '0) && !st_valid;
  end

endmodule

// File: rtl/wbuf_chk.sv
`timescale 1ns/1ps
// Port-level checker, tracks occupancy from the two handshakes.
module wbuf_chk
  import wbuf_pkg::*;
#(
  parameter int       DEPTH = 4,
  parameter int       AW    = 16,
  parameter int       DW    = 32,
  parameter wb_mode_e MODE  = WB_FORWARD,
  localparam int      SW    = DW / 8,
  localparam int      CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_valid,
  input logic          st_ready,
  input logic [AW-1:0] st_addr,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_data,
  input logic [SW-1:0] mem_strb,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_mem_data,
  input logic [DW-1:0] rd_data,
  input logic          rd_hit,
  input logic          rd_go
);

  logic [CW-1:0] occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + CW'(st_valid && st_ready) - CW'(mem_valid && mem_ready);
  end

  p_ready_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st_ready == (occ != CW'(DEPTH)));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CW'(DEPTH)) |-> !st_ready);

  p_valid_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid == (occ != '0));

  p_drain_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_data) && $stable(mem_strb)));

  p_reset_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (st_ready && !mem_valid));

  if (MODE == WB_FORWARD) begin : g_fwd
    p_miss_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |-> (rd_data == rd_mem_data));
    p_new_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_ready && st_addr == rd_addr) |-> rd_hit);
    p_go_always_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go);
  end else begin : g_flush
    p_go_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go |-> (!mem_valid && !st_valid));
    p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data == rd_mem_data) && !rd_hit);
  end

endmodule

bind wbuf_fwd wbuf_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .MODE(MODE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .st_valid    (st_valid),
  .st_ready    (st_ready),
  .st_addr     (st_addr),
  .mem_valid   (mem_valid),
  .mem_ready   (mem_ready),
  .mem_addr    (mem_addr),
  .mem_data    (mem_data),
  .mem_strb    (mem_strb),
  .rd_addr     (rd_addr),
  .rd_mem_data (rd_mem_data),
  .rd_data     (rd_data),
  .rd_hit      (rd_hit),
  .rd_go       (rd_go)
);

// File: tb/sim_wbuf_fwd.sv
`timescale 1ns/1ps
module sim_wbuf_fwd;
  import wbuf_pkg::*;

  localparam int DEPTH = 4;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int SW    = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_valid = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [SW-1:0] st_strb = '0;
  logic          mem_ready = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_mem_data = '0;

  logic          f_st_ready, f_mem_valid, f_rd_hit, f_rd_go;
  logic [AW-1:0] f_mem_addr;
  logic [DW-1:0] f_mem_data, f_rd_data;
  logic [SW-1:0] f_mem_strb;
  logic          s_st_ready, s_mem_valid, s_rd_hit, s_rd_go;
  logic [AW-1:0] s_mem_addr;
  logic [DW-1:0] s_mem_data, s_rd_data;
  logic [SW-1:0] s_mem_strb;

  always #2.5 clk = ~clk;

  wbuf_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .MODE(WB_FORWARD)) u0 (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(f_st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_strb(st_strb),
    .mem_valid(f_mem_valid), .mem_ready(mem_ready), .mem_addr(f_mem_addr),
    .mem_data(f_mem_data), .mem_strb(f_mem_strb), .rd_addr(rd_addr),
    .rd_mem_data(rd_mem_data), .rd_data(f_rd_data), .rd_hit(f_rd_hit), .rd_go(f_rd_go));

  wbuf_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .MODE(WB_FLUSH_FIRST)) u1 (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(s_st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_strb(st_strb),
    .mem_valid(s_mem_valid), .mem_ready(mem_ready), .mem_addr(s_mem_addr),
    .mem_data(s_mem_data), .mem_strb(s_mem_strb), .rd_addr(rd_addr),
    .rd_mem_data(rd_mem_data), .rd_data(s_rd_data), .rd_hit(s_rd_hit), .rd_go(s_rd_go));

  // Reference state
  logic [AW-1:0] qa[$];
  logic [DW-1:0] qd[$];
  logic [SW-1:0] qs[$];
  logic [DW-1:0] refmem [0:7];
  logic [DW-1:0] shadow [0:7];
  logic          held = 1'b0;
  logic [AW-1:0] held_a;
  logic [DW-1:0] held_d;
  logic [SW-1:0] held_s;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            finished = 1'b0;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [SW-1:0] strb);
    logic [DW-1:0] r = old_w;
    for (int b = 0; b < SW; b++) if (strb[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic step(input logic sv, input logic [2:0] sa, input logic [DW-1:0] sd,
                      input logic [SW-1:0] ss, input logic mr, input logic [2:0] ra);
    logic fire, pop, exp_hit;
    logic [DW-1:0] exp_rd;
    string tag;
    @(negedge clk);
    st_valid = sv; st_addr = AW'(sa); st_data = sd; st_strb = ss;
    mem_ready = mr; rd_addr = AW'(ra); rd_mem_data = refmem[ra];
    #1;
    fire = sv && (qa.size() < DEPTH);
    pop  = (qa.size() > 0) && mr;
    tag  = (qa.size() == DEPTH) ? "R2" : "R1";
    chk(tag, f_st_ready, qa.size() < DEPTH);
    chk(tag, s_st_ready, qa.size() < DEPTH);
    chk("R3", f_mem_valid, qa.size() > 0);
    chk("R3", s_mem_valid, qa.size() > 0);
    if (qa.size() > 0) begin
      chk("R3", {f_mem_addr, f_mem_strb}, {qa[0], qs[0]});
      chk("R3", f_mem_data, qd[0]);
      chk("R3", {s_mem_addr, s_mem_strb, s_mem_data}, {qa[0], qs[0], qd[0]});
    end
    if (held) begin
      chk("R4", {f_mem_addr, f_mem_strb, f_mem_data}, {held_a, held_s, held_d});
      chk("R4", {s_mem_addr, s_mem_strb, s_mem_data}, {held_a, held_s, held_d});
    end
    // Forward mode: the merged word equals the program-order value.
    exp_rd  = shadow[ra];
    exp_hit = 1'b0;
    foreach (qa[i]) if (qa[i] == AW'(ra)) exp_hit = 1'b1;
    if (fire && sa == ra) begin
      exp_rd  = merge(exp_rd, sd, ss);
      exp_hit = 1'b1;
    end
    if (fire && sa == ra) tag = "R7";
    else if (pop && qa[0] == AW'(ra)) tag = "R8";
    else tag = "R6";
    chk(tag, f_rd_data, exp_rd);
    chk(tag, f_rd_hit, exp_hit);
    chk("R10", f_rd_go, 1'b1);
    // Flush-first mode
    chk("R9", s_rd_go, (qa.size() == 0) && !sv);
    chk("R9", {s_rd_hit, s_rd_data}, {1'b0, refmem[ra]});
    if (s_rd_go) chk("R9", refmem[ra], shadow[ra]);
    // Model update for the coming edge
    held = (qa.size() > 0) && !mr;
    if (held) begin held_a = qa[0]; held_d = qd[0]; held_s = qs[0]; end
    if (pop) begin
      refmem[qa[0][2:0]] = merge(refmem[qa[0][2:0]], qd[0], qs[0]);
      void'(qa.pop_front()); void'(qd.pop_front()); void'(qs.pop_front());
    end
    if (fire) begin
      qa.push_back(AW'(sa)); qd.push_back(sd); qs.push_back(ss);
      shadow[sa] = merge(shadow[sa], sd, ss);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) begin
      refmem[i] = 32'h1000_0000 + i;
      shadow[i] = 32'h1000_0000 + i;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R5", {f_st_ready, f_mem_valid}, 2'b10);
    chk("R5", {s_st_ready, s_mem_valid}, 2'b10);

    // R7: store and lookup of the same word in one cycle on an empty buffer
    step(1'b1, 3'd5, 32'hAABB_CCDD, 4'b0101, 1'b0, 3'd5);
    // R2: fill past capacity with the drain stalled, overlapping bytes at word 2
    step(1'b1, 3'd2, 32'h1111_1111, 4'b1111, 1'b0, 3'd2);
    step(1'b1, 3'd2, 32'h2222_2222, 4'b0011, 1'b0, 3'd2);
    step(1'b1, 3'd3, 32'h3333_3333, 4'b1000, 1'b0, 3'd2);
    step(1'b1, 3'd2, 32'h4444_4444, 4'b0110, 1'b0, 3'd2);
    step(1'b1, 3'd2, 32'h5555_5555, 4'b1111, 1'b0, 3'd2);
    // R8: drain while looking up the leaving entry
    step(1'b0, 3'd0, 32'h0, 4'b0, 1'b1, 3'd5);
    step(1'b0, 3'd0, 32'h0, 4'b0, 1'b1, 3'd2);
    step(1'b1, 3'd2, 32'h6666_6666, 4'b1001, 1'b1, 3'd2);
    repeat (6) step(1'b0, 3'd0, 32'h0, 4'b0, 1'b1, 3'd2);

    // Random traffic over a small address set
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 10) < 6, 3'($urandom), $urandom, 4'($urandom),
           ($urandom % 10) < ((n / 500) % 2 == 0 ? 5 : 8), 3'($urandom));
    end
    repeat (DEPTH + 2) step(1'b0, 3'd0, 32'h0, 4'b0, 1'b1, 3'($urandom));
    for (int a = 0; a < 8; a++) chk("R3", refmem[a], shadow[a]);
    summary();
  end

endmodule